// File: doc/BRIEF.md
# Dual-Supply Undervoltage Fault Supervisor

This block supervises the two supplies of an isolated gate driver. Each supply arrives as a digitised undervoltage flag from an analog comparator. Each flag passes through its own debounce counter, which accepts it only after it has stayed high for a set number of cycles. An accepted undervoltage on either side, or a short-circuit request from the protection sequencer, puts the block into its fault state. In that state the gate output is forced low and the open-drain fault output is pulled low.

Release is handled by one hold timer that serves both fault kinds. After every cause has cleared, the fault stays asserted for a programmable number of cycles. A new cause that arrives during the hold restarts the count. A hold of zero cycles is supported. When a test strap is high, the input-side check is disabled and the output-side check keeps running. The block starts in the fault state after reset.

Top module: `uv_fault_supervisor`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, `fault_active` and `force_low` are 1 and `hold_done` is 0. With no cause present, both fall at the (HOLD_CYC+1)-th rising edge after reset is released.
- R2: An input-side flag (`uv_in_raw`) sampled high on MASK_CYC consecutive edges sets `fault_active` at the next edge, which is edge MASK_CYC+1 counted from the first high sample.
- R3: A flag that stays high for fewer than MASK_CYC edges causes no fault. A single low sample clears its count, so two such pulses separated by one low cycle also cause no fault.
- R4: The output-side flag (`uv_out_raw`) has its own debounce counter with the same timing as R2. Overlapping short pulses on the two flags never combine into a fault.
- R5: While `test_strap` is 1, `uv_in_raw` has no effect, and `uv_out_raw` still behaves as in R4.
- R6: `scp_req` sampled high sets `fault_active` at that same edge, with no mask delay.
- R7: After the last edge that samples a cause, the fault stays high for HOLD_CYC more edges and falls at the one after. `hold_done` is 1 for exactly the cycle in which `fault_active` has just fallen.
- R8: A cause that is sampled while the hold is running, including at the edge where release would happen, restarts the hold count from zero.
- R9: With HOLD_CYC = 0, the fault falls at the first edge that samples no cause.
- R10: `force_low` equals `fault_active` in every cycle.
- R11: The fault stays asserted for as long as an accepted undervoltage flag or `scp_req` is held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_in_raw | input | 1 | Input-side undervoltage comparator flag |
| uv_out_raw | input | 1 | Output-side undervoltage comparator flag |
| test_strap | input | 1 | 1 disables the input-side check |
| scp_req | input | 1 | Short-circuit fault request |
| fault_active | output | 1 | 1 while the fault output is pulled low |
| force_low | output | 1 | 1 while the gate output must be held low |
| hold_done | output | 1 | One-cycle pulse when the hold has elapsed and the fault is released |

## Verification
An undervoltage flag sampled high from edge 1 raises the fault at edge MASK_CYC+1. A short-circuit request raises it at the edge that samples it. The fault falls HOLD_CYC+1 edges after the last edge that sampled a cause. For a flag pulse of L edges, the fault is therefore high for L+1+HOLD_CYC-MASK_CYC samples when L is at least MASK_CYC. For a short-circuit pulse of L edges it is high for L+HOLD_CYC samples. The bench changes its inputs 1 ns after a rising edge and reads the outputs at that same point, so sample k shows the state left by edge k. It sweeps pulse lengths on two instances, one of them with a zero hold, and compares the first-high index, the high count and the position of the `hold_done` pulse against these formulas.

// File: rtl/uvs_pkg.sv
package uvs_pkg;
  typedef enum int unsigned {SUP_IN = 0, SUP_OUT = 1} supply_e;
  localparam int unsigned NUM_SUP = 2;

  function automatic int unsigned cnt_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/uvs_mask_filter.sv
module uvs_mask_filter #(
  parameter int unsigned MASK_CYC = 2500
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic qual
);
  localparam int unsigned CW = uvs_pkg::cnt_w(MASK_CYC);
  localparam logic [CW-1:0] LAST = CW'(MASK_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      qual <= 1'b0;
    end else if (!raw) begin
      cnt  <= '0;
      qual <= 1'b0;
    end else if (!qual) begin
      if (cnt == LAST) qual <= 1'b1;
      else             cnt  <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/uvs_hold_timer.sv
module uvs_hold_timer #(
  parameter int unsigned HOLD_CYC = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic cause,
  output logic fault,
  output logic force_lo,
  output logic done
);
  localparam int unsigned HW = uvs_pkg::cnt_w(HOLD_CYC + 1);
  localparam logic [HW-1:0] HEND = HW'(HOLD_CYC);

  logic [HW-1:0] hcnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      fault    <= 1'b1;
      force_lo <= 1'b1;
      done     <= 1'b0;
      hcnt     <= '0;
    end else if (cause) begin
      fault    <= 1'b1;
      force_lo <= 1'b1;
      done     <= 1'b0;
      hcnt     <= '0;
    end else if (fault) begin
      if (hcnt == HEND) begin
        fault    <= 1'b0;
        force_lo <= 1'b0;
        done     <= 1'b1;
      end else begin
        hcnt <= hcnt + 1'b1;
        done <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end
endmodule

// File: rtl/uv_fault_supervisor.sv
module uv_fault_supervisor #(
  parameter int unsigned MASK_CYC = 2500,
  parameter int unsigned HOLD_CYC = 500000
) (
  input  logic clk,
  input  logic rst,
  input  logic uv_in_raw,
  input  logic uv_out_raw,
  input  logic test_strap,
  input  logic scp_req,
  output logic fault_active,
  output logic force_low,
  output logic hold_done
);
  import uvs_pkg::*;

  logic [NUM_SUP-1:0] raw_g;
  logic [NUM_SUP-1:0] qual;
  logic               cause;

  assign raw_g[SUP_IN]  = uv_in_raw & ~test_strap;
  assign raw_g[SUP_OUT] = uv_out_raw;

  for (genvar g = 0; g < NUM_SUP; g++) begin : g_sup
    uvs_mask_filter #(.MASK_CYC(MASK_CYC)) u_mask (
      .clk  (clk),
      .rst  (rst),
      .raw  (raw_g[g]),
      .qual (qual[g])
    );
  end

  assign cause = (|qual) | scp_req;

  uvs_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_hold (
    .clk      (clk),
    .rst      (rst),
    .cause    (cause),
    .fault    (fault_active),
    .force_lo (force_low),
    .done     (hold_done)
  );
endmodule

// File: rtl/uvs_chk.sv
module uvs_chk (
  input logic clk,
  input logic rst,
  input logic uv_in_raw,
  input logic uv_out_raw,
  input logic test_strap,
  input logic scp_req,
  input logic fault_active,
  input logic force_low,
  input logic hold_done
);
  // R6
  scp_sets_chk: assert property (@(posedge clk) disable iff (rst)
    scp_req |=> fault_active);

  // R2
  rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(fault_active) |-> ($past(scp_req) || $past(uv_out_raw, 2) ||
                             ($past(uv_in_raw, 2) && !$past(test_strap, 2))));

  // R7
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    hold_done |-> (!fault_active && $past(fault_active)));

  // R10
  force_match_chk: assert property (@(posedge clk) disable iff (rst)
    force_low == fault_active);
endmodule

bind uv_fault_supervisor uvs_chk u_chk (
  .clk          (clk),
  .rst          (rst),
  .uv_in_raw    (uv_in_raw),
  .uv_out_raw   (uv_out_raw),
  .test_strap   (test_strap),
  .scp_req      (scp_req),
  .fault_active (fault_active),
  .force_low    (force_low),
  .hold_done    (hold_done)
);

// File: tb/sim_uv_fault_supervisor.sv
`timescale 1ns/1ps
module sim_uv_fault_supervisor;
  localparam int M0 = 4, H0 = 6;
  localparam int M1 = 3, H1 = 0;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic uv_in_raw = 1'b0, uv_out_raw = 1'b0, test_strap = 1'b0, scp_req = 1'b0;
  logic [1:0] fa, fl, hd;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  uv_fault_supervisor #(.MASK_CYC(M0), .HOLD_CYC(H0)) u0 (
    .clk(clk), .rst(rst), .uv_in_raw(uv_in_raw), .uv_out_raw(uv_out_raw),
    .test_strap(test_strap), .scp_req(scp_req),
    .fault_active(fa[0]), .force_low(fl[0]), .hold_done(hd[0]));

  uv_fault_supervisor #(.MASK_CYC(M1), .HOLD_CYC(H1)) u1 (
    .clk(clk), .rst(rst), .uv_in_raw(uv_in_raw), .uv_out_raw(uv_out_raw),
    .test_strap(test_strap), .scp_req(scp_req),
    .fault_active(fa[1]), .force_low(fl[1]), .hold_done(hd[1]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // {in, out, scp} to be sampled at edge k
  function automatic logic [2:0] stim(input int mode, input int len, input int k);
    logic [2:0] v = 3'b000;
    case (mode)
      0: v[2] = (k >= 1 && k <= len);
      1: v[1] = (k >= 1 && k <= len);
      2: v[0] = (k >= 1 && k <= len);
      3: v[2] = (k >= 1 && k <= len) || (k >= len + 2 && k <= 2*len + 1);
      4: begin v[2] = (k >= 1 && k <= len); v[1] = (k >= 2 && k <= len + 1); end
      5: v[0] = (k == 1) || (k == 1 + len);
      default: v = 3'b000;
    endcase
    return v;
  endfunction

  function automatic int exp_cnt(input int mode, input int len, input int m, input int h, input bit strap);
    case (mode)
      0: return (strap || len < m) ? 0 : len + 1 + h - m;
      1: return (len < m) ? 0 : len + 1 + h - m;
      2: return len + h;
      3, 4: return 0;
      5: return (len <= h + 1) ? 1 + len + h : 2 * (1 + h);
      default: return 0;
    endcase
  endfunction

  function automatic int exp_first(input int mode, input int m);
    return (mode == 0 || mode == 1) ? m + 1 : 1;
  endfunction

  function automatic int exp_dones(input int mode, input int len, input int h, input int cnt);
    if (cnt == 0) return 0;
    if (mode == 5 && len > h + 1) return 2;
    return 1;
  endfunction

  task automatic run(input int mode, input int len, input string req);
    int win = 2 * len + 20;
    int cnt[2], first[2], last_hi[2], dones[2], last_done[2], mism[2];
    logic [2:0] v;
    for (int u = 0; u < 2; u++) begin
      cnt[u] = 0; first[u] = 0; last_hi[u] = 0; dones[u] = 0; last_done[u] = 0; mism[u] = 0;
    end
    @(negedge clk);
    v = stim(mode, len, 1);
    {uv_in_raw, uv_out_raw, scp_req} = v;
    for (int i = 1; i <= win; i++) begin
      @(posedge clk); #1;
      for (int u = 0; u < 2; u++) begin
        if (fa[u]) begin
          if (cnt[u] == 0) first[u] = i;
          cnt[u]++;
          last_hi[u] = i;
        end
        if (hd[u]) begin dones[u]++; last_done[u] = i; end
        if (fl[u] != fa[u]) mism[u]++;
      end
      v = stim(mode, len, i + 1);
      {uv_in_raw, uv_out_raw, scp_req} = v;
    end
    for (int u = 0; u < 2; u++) begin
      int m = (u == 0) ? M0 : M1;
      int h = (u == 0) ? H0 : H1;
      int ec = exp_cnt(mode, len, m, h, test_strap);
      chk(cnt[u] == ec, $sformatf("%s high-count u%0d mode%0d len%0d", req, u, mode, len), cnt[u], ec);
      if (ec != 0) begin
        chk(first[u] == exp_first(mode, m), $sformatf("%s first-high u%0d mode%0d len%0d", req, u, mode, len),
            first[u], exp_first(mode, m));
        // R7: pulse sits right after the last high sample
        chk(last_done[u] == last_hi[u] + 1, $sformatf("R7 done-position u%0d mode%0d len%0d", u, mode, len),
            last_done[u], last_hi[u] + 1);
      end
      chk(dones[u] == exp_dones(mode, len, h, ec), $sformatf("R7 done-count u%0d mode%0d len%0d", u, mode, len),
          dones[u], exp_dones(mode, len, h, ec));
      chk(mism[u] == 0, $sformatf("R10 force mismatch u%0d mode%0d", u, mode), mism[u], 0);
    end
  endtask

  initial begin
    int c0, c1;
    repeat (3) @(posedge clk);
    #1;
    // R1 during reset
    for (int u = 0; u < 2; u++) begin
      chk(fa[u] == 1'b1, $sformatf("R1 reset fault u%0d", u), fa[u], 1);
      chk(fl[u] == 1'b1, $sformatf("R1 reset force u%0d", u), fl[u], 1);
      chk(hd[u] == 1'b0, $sformatf("R1 reset done u%0d", u), hd[u], 0);
    end
    @(negedge clk);
    rst = 1'b0;
    c0 = 0; c1 = 0;
    for (int i = 1; i <= H0 + 5; i++) begin
      @(posedge clk); #1;
      if (fa[0]) c0++;
      if (fa[1]) c1++;
    end
    // R1 / R9: release after HOLD_CYC+1 edges
    chk(c0 == H0, "R1 release after reset u0", c0, H0);
    chk(c1 == H1, "R9 release after reset u1", c1, H1);

    for (int l = 1; l <= M0 + 3; l++) run(0, l, "R2");
    for (int l = 1; l <= M0 + 3; l++) run(1, l, "R4");
    for (int l = 1; l <= 5; l++) run(2, l, "R6");
    run(0, 30, "R11");
    run(2, 25, "R11");
    run(3, M1 - 1, "R3");
    run(4, M1 - 1, "R4");
    run(5, 3, "R8");
    run(5, H0 + 1, "R8");
    run(5, H0 + 2, "R8");
    test_strap = 1'b1;
    run(0, M0 + 3, "R5");
    run(0, 12, "R5");
    run(1, M0 + 2, "R5");
    test_strap = 1'b0;
    run(0, M0, "R9");

    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      total++;
      bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule